// File: doc/BRIEF.md
# Three-Bus Execution Datapath

This block is the execution unit of a small soft processor. Each cycle it takes one 16-bit control word. The word names two source operands, one ALU operation and one destination. The two sources are driven onto two operand buses and combined by the ALU. The result travels on a third bus and is written to exactly one destination: a general register, the memory address register or the memory data register.

The memory address and memory data registers can be loaded only from the result bus. Every address and every stored word is therefore an ALU result. A load moves the memory data register into a general register by routing it through the ALU. Because of this, indexed addressing such as a register sum or difference costs no extra cycle, and an arithmetic adjustment on loaded or stored data costs none either.

The control stream is qualified by `ctl_valid`. The block accepts a word in every cycle and never applies back-pressure, so there is no ready signal. When `ctl_valid` is low, the word has no effect.

Top module: `exec_datapath`

## Requirements
- R1: `ctl_word` is decoded with the ALU operation in bits 15:12, the first source in bits 11:8, the second source in bits 7:4 and the destination in bits 3:0. `res_data` shows the ALU result for the current word in the same cycle.
- R2: ALU operation codes: 0 passes the first source, 1 adds, 2 subtracts (first minus second), 3 is AND, 4 is OR, 5 is XOR, and 6 passes the second source.
- R3: Every ALU operation code from 7 to 15 yields zero.
- R4: Source codes 0 to 11 read general registers 0 to 11. Source code 13 reads the memory data register. Source code 14, and every other code, drives zero.
- R5: Destination codes 0 to 11 write only the named general register, at the next rising edge. All other registers keep their values.
- R6: Destination code 12 loads the memory address register from the result bus. `mem_addr` presents the new address from the next cycle on, and the address changes at no other time.
- R7: Destination code 13 raises `mem_wr` in the same cycle, with `mem_wdata` equal to the result and `mem_addr` equal to the current address register. The memory data register also takes the result.
- R8: In the cycle after the address register is written, `mem_rd` is high and the memory data register captures `mem_rdata` at the end of that cycle. The loaded word can be read as a source from the following cycle.
- R9: If a destination-13 write falls in the same cycle as a reload, the written result wins over `mem_rdata`.
- R10: While `ctl_valid` is low, no register is written and `mem_wr` stays low.
- R11: After reset, all general registers, the address register and the data register are zero, and `mem_rd` and `mem_wr` are low.
- R12: Destination codes 14 and 15 write nothing, while `res_data` still shows the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_valid | input | 1 | Control word qualifier |
| ctl_word | input | 16 | Operation, first source, second source and destination fields |
| res_data | output | 32 | Result bus value for the current word |
| mem_addr | output | 32 | Memory address, equal to the address register |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Memory write data |
| mem_rd | output | 1 | Reload cycle indicator; memory data is expected on `mem_rdata` |
| mem_rdata | input | 32 | Memory read data, valid while `mem_rd` is high |

## Verification
The assertions assume that the memory returns the word at `mem_addr` on `mem_rdata` combinationally while `mem_rd` is high. The bench's memory model provides exactly that: an array indexed by the low address bits. Apart from this, the assertions assume only that the control word is stable across each rising edge. The bench meets this by driving every word on the falling edge and sampling results a short delay later. Operands are brought into registers only through the block's own load path, with the bench pre-setting memory word zero, so no internal state is forced.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam int CODE_W = 4;
  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [CODE_W-1:0] {
    ALU_PASS_A = 4'h0,
    ALU_ADD    = 4'h1,
    ALU_SUB    = 4'h2,
    ALU_AND    = 4'h3,
    ALU_OR     = 4'h4,
    ALU_XOR    = 4'h5,
    ALU_PASS_B = 4'h6
  } alu_op_e;

  // field positions matter: upstream sequencer packs words this way
  typedef struct packed {
    code_t op;
    code_t src_a;
    code_t src_b;
    code_t dst;
  } ctl_word_t;

  localparam code_t DST_ADDR = 4'hC;
  localparam code_t DST_DATA = 4'hD;
  localparam code_t SRC_DATA = 4'hD;
  localparam code_t SRC_ZERO = 4'hE;
endpackage

// File: rtl/exec_regfile.sv
module exec_regfile
  import exec_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  code_t             wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  code_t             rd_a_sel,
  input  code_t             rd_b_sel,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);
  logic [DATA_W-1:0] gpr_q [NUM_REGS];
  logic [NUM_REGS-1:0] slot_we;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    assign slot_we[i] = wr_en && (wr_sel == CODE_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) gpr_q[i] <= '0;
      else if (slot_we[i]) gpr_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_a = '0;
    rd_b = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rd_a_sel == CODE_W'(k)) rd_a = gpr_q[k];
      if (rd_b_sel == CODE_W'(k)) rd_b = gpr_q[k];
    end
  end

  // a single destination per word: at most one register slot enabled
  assert_single_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_we));

  // no enabled slot means the named register holds its value
  assert_slot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_we[0] |=> $stable(gpr_q[0]));
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  code_t             op,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result
);
  always_comb begin
    unique case (op)
      ALU_PASS_A: result = opnd_a;
      ALU_ADD:    result = opnd_a + opnd_b;
      ALU_SUB:    result = opnd_a - opnd_b;
      ALU_AND:    result = opnd_a & opnd_b;
      ALU_OR:     result = opnd_a | opnd_b;
      ALU_XOR:    result = opnd_a ^ opnd_b;
      ALU_PASS_B: result = opnd_b;
      default:    result = '0;
    endcase
  end
endmodule

// File: rtl/exec_memif.sv
module exec_memif #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic              data_we,
  input  logic [DATA_W-1:0] bus3,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              reload
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      reload <= 1'b0;
    end else begin
      reload <= addr_we;
      if (addr_we) addr_q <= bus3;
      // explicit store beats the pending reload
      if (data_we) data_q <= bus3;
      else if (reload) data_q <= mem_rdata;
    end
  end

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_we |=> $stable(addr_q));

  assert_reload_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we |=> reload);

  assert_reload_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !data_we) |=> (data_q == $past(mem_rdata)));

  assert_store_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> (data_q == $past(bus3)));
endmodule

// File: rtl/exec_datapath.sv
module exec_datapath
  import exec_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_valid,
  input  logic [15:0]       ctl_word,
  output logic [DATA_W-1:0] res_data,
  output logic [DATA_W-1:0] mem_addr,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata
);
  ctl_word_t         cw;
  logic [DATA_W-1:0] gpr_a, gpr_b, bus1, bus2, bus3;
  logic [DATA_W-1:0] addr_q, data_q;
  logic              gpr_we, addr_we, data_we;

  assign cw = ctl_word_t'(ctl_word);

  function automatic logic [DATA_W-1:0] pick_src(
    input code_t sel, input logic [DATA_W-1:0] gpr, input logic [DATA_W-1:0] mbr);
    if (sel == SRC_DATA) return mbr;
    else if (sel == SRC_ZERO) return '0;
    else if (int'(sel) < NUM_REGS) return gpr;
    else return '0;
  endfunction

  assign bus1 = pick_src(cw.src_a, gpr_a, data_q);
  assign bus2 = pick_src(cw.src_b, gpr_b, data_q);

  assign gpr_we  = ctl_valid && (int'(cw.dst) < NUM_REGS);
  assign addr_we = ctl_valid && (cw.dst == DST_ADDR);
  assign data_we = ctl_valid && (cw.dst == DST_DATA);

  exec_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(gpr_we), .wr_sel(cw.dst), .wr_data(bus3),
    .rd_a_sel(cw.src_a), .rd_b_sel(cw.src_b), .rd_a(gpr_a), .rd_b(gpr_b)
  );

  exec_alu #(.DATA_W(DATA_W)) u_alu (
    .op(cw.op), .opnd_a(bus1), .opnd_b(bus2), .result(bus3)
  );

  exec_memif #(.DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .data_we(data_we), .bus3(bus3),
    .mem_rdata(mem_rdata), .addr_q(addr_q), .data_q(data_q), .reload(mem_rd)
  );

  assign res_data  = bus3;
  assign mem_addr  = addr_q;
  assign mem_wr    = data_we;
  assign mem_wdata = bus3;

  assert_idle_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_valid |-> !mem_wr);

  assert_store_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (mem_addr == $past(mem_addr)));

  assert_addr_from_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we |=> (mem_addr == $past(res_data)));
endmodule

// File: tb/exec_datapath_test.sv
module exec_datapath_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_valid = 1'b0;
  logic [15:0] ctl_word = 16'h0EEF;
  logic [31:0] res_data, mem_addr, mem_wdata, mem_rdata;
  logic        mem_wr, mem_rd;
  logic [31:0] mem [256];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  exec_datapath uut (
    .clk(clk), .rst_n(rst_n), .ctl_valid(ctl_valid), .ctl_word(ctl_word),
    .res_data(res_data), .mem_addr(mem_addr), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", req, got, exp);
    end
  endtask

  // drive a word on the falling edge; results are visible after a short delay
  task automatic drive(input logic v, input logic [3:0] op, input logic [3:0] a,
                       input logic [3:0] b, input logic [3:0] d);
    @(negedge clk);
    ctl_valid = v;
    ctl_word = {op, a, b, d};
    #1;
  endtask

  task automatic peek(input logic [3:0] src, output logic [31:0] v);
    drive(1'b1, 4'h0, src, 4'hE, 4'hF);
    v = res_data;
  endtask

  task automatic load_reg(input logic [3:0] n, input logic [31:0] val);
    mem[0] = val;
    drive(1'b1, 4'h0, 4'hE, 4'hE, 4'hC);
    drive(1'b0, 4'h0, 4'hE, 4'hE, 4'hF);
    drive(1'b1, 4'h0, 4'hD, 4'hE, n);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    #1;
    chk("R11 mem_addr", mem_addr, 0);
    chk("R11 mem_rd", {31'b0, mem_rd}, 0);
    chk("R11 mem_wr", {31'b0, mem_wr}, 0);
    peek(4'h0, v); chk("R11 r0", v, 0);
    peek(4'hB, v); chk("R11 r11", v, 0);
    peek(4'hD, v); chk("R11 data reg", v, 0);
  endtask

  task automatic t_alu;
    load_reg(4'h1, 32'd100);
    load_reg(4'h2, 32'd30);
    drive(1'b1, 4'h0, 4'h1, 4'h2, 4'hF); chk("R2 pass a", res_data, 100);
    drive(1'b1, 4'h1, 4'h1, 4'h2, 4'hF); chk("R1 R2 add", res_data, 130);
    drive(1'b1, 4'h2, 4'h1, 4'h2, 4'hF); chk("R2 sub", res_data, 70);
    drive(1'b1, 4'h2, 4'h2, 4'h1, 4'hF); chk("R1 sub order", res_data, 32'hFFFF_FFBA);
    drive(1'b1, 4'h3, 4'h1, 4'h2, 4'hF); chk("R2 and", res_data, 100 & 30);
    drive(1'b1, 4'h4, 4'h1, 4'h2, 4'hF); chk("R2 or", res_data, 100 | 30);
    drive(1'b1, 4'h5, 4'h1, 4'h2, 4'hF); chk("R2 xor", res_data, 100 ^ 30);
    drive(1'b1, 4'h6, 4'h1, 4'h2, 4'hF); chk("R2 pass b", res_data, 30);
    drive(1'b1, 4'h7, 4'h1, 4'h2, 4'hF); chk("R3 op7", res_data, 0);
    drive(1'b1, 4'hF, 4'h1, 4'h2, 4'hF); chk("R3 op15", res_data, 0);
  endtask

  task automatic t_sources;
    logic [31:0] v;
    drive(1'b1, 4'h1, 4'hE, 4'h1, 4'hF); chk("R4 zero src", res_data, 100);
    drive(1'b1, 4'h1, 4'hC, 4'hF, 4'hF); chk("R4 codes 12/15 zero", res_data, 0);
    peek(4'hD, v); chk("R4 data src", v, 30);
  endtask

  task automatic t_dest;
    logic [31:0] v;
    drive(1'b1, 4'h1, 4'h1, 4'h2, 4'h5);
    peek(4'h5, v); chk("R5 r5 written", v, 130);
    peek(4'h1, v); chk("R5 r1 kept", v, 100);
    peek(4'h4, v); chk("R5 r4 kept", v, 0);
    drive(1'b1, 4'h1, 4'h1, 4'h1, 4'hE); chk("R12 result shown", res_data, 200);
    chk("R12 no strobe", {31'b0, mem_wr}, 0);
    peek(4'h1, v); chk("R12 r1 kept", v, 100);
  endtask

  task automatic t_load;
    logic [31:0] v;
    mem[130] = 32'hABCD_1234;
    drive(1'b1, 4'h1, 4'h1, 4'h2, 4'hC);
    drive(1'b0, 4'h0, 4'hE, 4'hE, 4'hF);
    chk("R6 addr next cycle", mem_addr, 130);
    chk("R8 reload strobe", {31'b0, mem_rd}, 1);
    drive(1'b1, 4'h1, 4'hD, 4'h1, 4'h4);
    chk("R8 loaded word usable", res_data, 32'hABCD_1234 + 100);
    peek(4'h4, v); chk("R8 r4 load+offset", v, 32'hABCD_1298);
    chk("R8 rd low later", {31'b0, mem_rd}, 0);
    chk("R6 addr held", mem_addr, 130);
  endtask

  task automatic t_store;
    logic [31:0] v;
    drive(1'b1, 4'h2, 4'h1, 4'h2, 4'hD);
    chk("R7 strobe", {31'b0, mem_wr}, 1);
    chk("R7 addr", mem_addr, 130);
    chk("R7 wdata", mem_wdata, 70);
    peek(4'hD, v); chk("R7 data reg", v, 70);
    chk("R7 memory", mem[130], 70);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    mem[100] = 32'd555;
    drive(1'b1, 4'h0, 4'h1, 4'hE, 4'hC);
    drive(1'b1, 4'h0, 4'h2, 4'hE, 4'hD);
    chk("R9 reload cycle", {31'b0, mem_rd}, 1);
    peek(4'hD, v); chk("R9 store wins", v, 30);
  endtask

  task automatic t_idle;
    logic [31:0] v;
    drive(1'b0, 4'h1, 4'h1, 4'h2, 4'h3);
    drive(1'b0, 4'h1, 4'h1, 4'h2, 4'hD);
    chk("R10 no strobe", {31'b0, mem_wr}, 0);
    drive(1'b0, 4'h1, 4'h1, 4'h2, 4'hC);
    peek(4'h3, v); chk("R10 r3 untouched", v, 0);
    peek(4'hD, v); chk("R10 data untouched", v, 30);
    chk("R10 addr untouched", mem_addr, 100);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_alu;
    t_sources;
    t_dest;
    t_load;
    t_store;
    t_collide;
    t_idle;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule